// File: doc/BRIEF.md
# Four-Mode Self-Test Register

This block is an n-bit register that can take one of four roles in a self-testing datapath. As a plain pipeline register it captures a parallel word on every clock. As a pattern source it steps on its own through a linear feedback sequence, and each state serves as a stimulus word. As a response compactor it folds a stream of parallel words into a signature. As a scan segment it moves bits serially from a scan input to a scan output.

A two-bit mode input picks the role on every clock edge. Each value of the mode input selects one of four states: SHIFT (00), PATGEN (01), SIGN (10) and SYSTEM (11). Changing the mode input between two edges moves the block to the named state. Every state may follow any other, and no transition has extra conditions. The register contents carry over across a mode change, so a seed can be loaded in SYSTEM or SHIFT and then used in PATGEN or SIGN. The feedback polynomial is a parameter. Bit i of `POLY` is the coefficient of x^i, and the x^WIDTH term is implied. A coefficient of zero removes the XOR gate at that stage.

Top module: `bilbo_register`

## Requirements
- R1: While rst_n is low, the register clears on the clock edge, so par_out reads all zeros.
- R2: With mode 11 (SYSTEM), par_out equals the par_in value present at the previous clock edge.
- R3: With mode 00 (SHIFT), each edge moves the register one place toward the MSB and places scan_in in bit 0. scan_out always shows bit WIDTH-1, so a loaded word leaves MSB first.
- R4: With mode 01 (PATGEN), the next state is (q shifted left by one, with 0 in bit 0) XOR (POLY if bit WIDTH-1 of q was 1, otherwise 0). For the default POLY of 8'h1D, state 8'h01 steps to 8'h02 and state 8'h80 steps to 8'h1D.
- R5: In PATGEN, a nonzero state never steps to zero. With the default primitive polynomial, a seed returns to itself after exactly 2^WIDTH-1 steps.
- R6: With mode 10 (SIGN), the next state is the R4 step of q, XORed with par_in. This divides the input stream by the polynomial.
- R7: In PATGEN, par_in and scan_in have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode | input | 2 | Role select: 00 shift, 01 pattern, 10 signature, 11 system |
| par_in | input | WIDTH | Parallel data word |
| scan_in | input | 1 | Serial input into bit 0 |
| par_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Register bit WIDTH-1 |

## Verification
The pattern role is tested in three ways. Single steps from 8'h01 and 8'h80 show whether the taps sit in the right place and whether a zero coefficient really drops its XOR. A full walk from a seed back to that seed shows whether the sequence has the maximum length, and whether it ever reaches zero. The signature role is fed streams of pseudo-random words and compared with a software polynomial-division model: a wrong tap or a lost input bit changes the signature. The shift role is given an alternating load pattern together with a different serial pattern, which shows the bit order both on scan_out and on the parallel word.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_PATGEN = 2'b01,
        MODE_SIGN   = 2'b10,
        MODE_SYSTEM = 2'b11
    } bilbo_mode_e;
endpackage

// File: rtl/bilbo_feedback.sv
// One autonomous step of the internal-XOR feedback shift register.
module bilbo_feedback #(
    parameter int          WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY = 8'h1D
) (
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] step
);
    localparam int TOP = WIDTH - 1;

    logic fb;
    assign fb = q[TOP];

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            if (POLY[0]) begin : g_tap
                assign step[0] = fb;
            end else begin : g_notap
                assign step[0] = 1'b0;
            end
        end else begin : g_rest
            if (POLY[i]) begin : g_tap
                assign step[i] = q[i-1] ^ fb;
            end else begin : g_notap
                assign step[i] = q[i-1];
            end
        end
    end
endmodule

// File: rtl/bilbo_next.sv
// Next-state selection for the four roles.
module bilbo_next
    import bilbo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  bilbo_mode_e      mode,
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] step,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] nxt
);
    always_comb begin
        unique case (mode)
            MODE_SHIFT:  nxt = {q[WIDTH-2:0], scan_in};
            MODE_PATGEN: nxt = step;
            MODE_SIGN:   nxt = step ^ par_in;
            MODE_SYSTEM: nxt = par_in;
            default:     nxt = q;
        endcase
    end
endmodule

// File: rtl/bilbo_register.sv
module bilbo_register
    import bilbo_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] POLY  = 8'h1D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);
    localparam int TOP = WIDTH - 1;

    bilbo_mode_e      cur_mode;
    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] step;
    logic [WIDTH-1:0] nxt;

    assign cur_mode = bilbo_mode_e'(mode);

    bilbo_feedback #(.WIDTH(WIDTH), .POLY(POLY)) i_feedback (
        .q    (q),
        .step (step)
    );

    bilbo_next #(.WIDTH(WIDTH)) i_next (
        .mode    (cur_mode),
        .q       (q),
        .step    (step),
        .par_in  (par_in),
        .scan_in (scan_in),
        .nxt     (nxt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    // Outputs
    always_comb begin
        par_out  = q;
        scan_out = q[TOP];
    end

    // R1: reset clears the register
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> par_out == '0);

    // R2: system role captures the parallel word
    a_r2_system_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 |=> par_out == $past(par_in));

    // R3: shift role moves bits toward the MSB and takes scan_in into bit 0
    a_r3_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b00 |=> par_out == {$past(par_out[TOP-1:0]), $past(scan_in)});

    // R5: the pattern role never falls into the all-zero state
    a_r5_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && par_out != '0) |=> par_out != '0);

    // R4: a step with MSB clear is a plain left shift
    a_r4_plain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !scan_out) |=> par_out == {$past(par_out[TOP-1:0]), 1'b0});
endmodule

// File: tb/test_bilbo_register.sv
module test_bilbo_register;
    localparam int          W    = 8;
    localparam logic [W-1:0] POLY = 8'h1D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode = 2'b11;
    logic [W-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] par_out;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bilbo_register #(.WIDTH(W), .POLY(POLY)) i_bilbo_register (
        .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
        .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
    );

    function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
        return {s[W-2:0], 1'b0} ^ (s[W-1] ? POLY : '0);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] v);
        mode = 2'b11; par_in = v;
        tick();
    endtask

    task automatic t_reset;
        load(8'h5A);
        rst_n = 1'b0;
        tick();
        check("R1", par_out, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_system;
        load(8'hC3);
        check("R2", par_out, 8'hC3);
        load(8'h3C);
        check("R2", par_out, 8'h3C);
    endtask

    task automatic t_shift;
        logic [W-1:0] pat;
        pat = 8'h96;
        load(8'hA5);
        mode = 2'b00;
        for (int i = 0; i < W; i++) begin
            check("R3 scan_out", {7'b0, scan_out}, {7'b0, 1'(8'hA5 >> (W-1-i))});
            scan_in = pat[W-1-i];
            tick();
        end
        check("R3 word", par_out, pat);
    endtask

    task automatic t_patgen_steps;
        load(8'h01);
        mode = 2'b01;
        tick();
        check("R4 from 01", par_out, 8'h02);
        load(8'h80);
        mode = 2'b01;
        tick();
        check("R4 from 80", par_out, 8'h1D);
        tick();
        check("R4 from 1D", par_out, 8'h3A);
    endtask

    task automatic t_period;
        int n;
        bit zero_seen;
        load(8'h01);
        mode = 2'b01;
        n = 0; zero_seen = 0;
        do begin
            tick();
            n++;
            if (par_out == '0) zero_seen = 1;
        end while (par_out != 8'h01 && n < 400);
        check("R5 period", 8'(n), 8'd255);
        check("R5 no zero", {7'b0, zero_seen}, 8'h00);
    endtask

    task automatic t_ignore;
        logic [W-1:0] exp;
        load(8'h6B);
        exp = 8'h6B;
        mode = 2'b01;
        for (int i = 0; i < 6; i++) begin
            par_in = 8'hFF ^ 8'(i * 37);
            scan_in = i[0];
            tick();
            exp = ref_step(exp);
            check("R7", par_out, exp);
        end
    endtask

    task automatic t_misr(input int seed, input int len);
        logic [W-1:0] exp;
        logic [W-1:0] w;
        int unsigned rnd;
        rnd = $urandom(seed);
        load(8'h00);
        exp = 8'h00;
        mode = 2'b10;
        for (int i = 0; i < len; i++) begin
            rnd = $urandom;
            w = rnd[W-1:0];
            par_in = w;
            tick();
            exp = ref_step(exp) ^ w;
        end
        check("R6 signature", par_out, exp);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        tick();
        check("R1 initial", par_out, '0);
        rst_n = 1'b1;
        t_system();
        t_shift();
        t_patgen_steps();
        t_period();
        t_ignore();
        t_misr(11, 40);
        t_misr(97, 13);
        t_misr(5, 200);
        t_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule